// File: doc/BRIEF.md
# Host-to-DSP Parallel Port Bridge

This block joins a byte-wide external host bus to a 24-bit DSP core. The host sees a window of eight byte registers at a 3-bit address. These are a control byte, a status byte, a command vector, an interrupt vector and three data bytes. A 24-bit word is packed across the three data bytes. Reads of the data bytes return the word coming from the core. Writes to them build the word going to the core.

Each direction has two stages, so the writer can refill while the reader still holds the previous word. On the host side, a holding word is filled byte by byte and a completed word then moves into the core's receive register. On the core side, a transmit register feeds a host-visible receive word. The core has a 5-bit control register, a 5-bit status view and three maskable interrupts: receive full, transmit empty and host command. Each side publishes two flag bits that the other side can read. The host gets a request line, which it can withdraw with an acknowledge input. Both sides share one clock and use single-cycle strobes.

Top module: `hpi_bridge`

## Requirements
- R1: Reset leaves the core status at 5'b00010 (only transmit-empty set), the host status byte at 8'h02, every flag, enable, vector and data register at zero, and the request line and all interrupts low.
- R2: Host address 0 keeps bits 0, 1, 3 and 4 of a written byte (bit 2 reads 0). Address 3 is a full 8-bit read/write register. Address 1 reads back the written low seven bits, with bit 7 showing command-pending. Address 4 always reads zero.
- R3: The data bytes map as address 5 = bits 23:16, 6 = bits 15:8 and 7 = bits 7:0. A host write to address 7 while transmit-ready is set clears transmit-ready on that edge. One edge later, if receive-full is clear, the word moves to the core receive register, receive-full (core status bit 0) sets and transmit-ready sets again.
- R4: While receive-full is set, a completed host word waits in the holding stage with transmit-ready clear. A core read strobe clears receive-full, and the waiting word moves on the next edge.
- R5: Host writes to addresses 5, 6 and 7 are ignored while transmit-ready is clear.
- R6: A core transmit strobe while transmit-empty (core status bit 1) is set loads the word and clears transmit-empty. One edge later, if the host receive word is empty, the word moves there, receive-ready sets and transmit-empty sets. A core transmit strobe while transmit-empty is clear is ignored. A host read strobe at address 7 empties the host receive word.
- R7: The host status byte at address 2 holds bit 0 receive-ready, bit 1 transmit-ready, bit 2 command-pending, bits 3 and 4 the core's outbound flags, and zero elsewhere.
- R8: A host write to address 1 with bit 7 set raises command-pending (core status bit 2) on the next edge. A core command acknowledge clears it. When both happen in the same cycle, the set wins. A write with bit 7 clear leaves it unchanged.
- R9: Host control bits 3 and 4 appear as core status bits 3 and 4. Core control bits 3 and 4 appear as host status bits 3 and 4.
- R10: irq_rxf = receive-full AND core control bit 0. irq_txe = transmit-empty AND bit 1. irq_cmd = command-pending AND bit 2.
- R11: h_req is high when h_ack is low and either host control bit 0 is set with receive-ready, or bit 1 is set with transmit-ready.
- R12: A core control write strobe loads all five bits, which read back on c_ctl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (pops at address 7) |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte for h_addr |
| h_ack | input | 1 | Host acknowledge, withdraws h_req |
| h_req | output | 1 | Host request |
| c_tx_wr | input | 1 | Core transmit strobe |
| c_tx_data | input | 24 | Core transmit word |
| c_rx_rd | input | 1 | Core receive-read strobe |
| c_rx_data | output | 24 | Core receive word |
| c_ctl_wr | input | 1 | Core control write strobe |
| c_ctl_wdata | input | 5 | Core control write value |
| c_ctl | output | 5 | Core control register |
| c_stat | output | 5 | Core status view |
| c_cmd_ack | input | 1 | Core command acknowledge |
| irq_rxf | output | 1 | Receive-full interrupt |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_cmd | output | 1 | Host command interrupt |

## Verification
Host-to-core words are sent once into an empty path and once while the core still holds the previous word. This separates a direct move from a word that must wait in the holding stage, and stray byte writes made during the wait show whether blocked writes corrupt it. Core-to-host words are sent back to back, with a third strobe arriving while both stages are full, so a dropped, duplicated or overwritten word shows in the byte reads. The command bit is raised alone, cleared alone, and hit by a set and an acknowledge in the same cycle, which fixes the priority. A reference model runs alongside and compares every output on every clock.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    localparam int HPI_DW = 24;
    localparam int HPI_BW = 8;
    localparam int HPI_NB = HPI_DW / HPI_BW;

    typedef enum logic [2:0] {
        A_CTL  = 3'd0,
        A_CVEC = 3'd1,
        A_STAT = 3'd2,
        A_IVEC = 3'd3,
        A_GAP  = 3'd4,
        A_DHI  = 3'd5,
        A_DMID = 3'd6,
        A_DLO  = 3'd7
    } haddr_e;

    // core control: bit0 rie, bit1 tie, bit2 cie, bits3-4 outbound flags
    typedef struct packed {
        logic hfb;
        logic hfa;
        logic cie;
        logic tie;
        logic rie;
    } cctl_t;

    // host control: bit0 receive request, bit1 transmit request, bits3-4 flags
    typedef struct packed {
        logic hfb;
        logic hfa;
        logic spare;
        logic treq;
        logic rreq;
    } hctl_t;

    typedef struct packed {
        logic hfb;
        logic hfa;
        logic hcp;
        logic txde;
        logic rxf;
    } cstat_t;

    localparam logic [4:0] HCTL_MASK = 5'b11011;

    function automatic logic [HPI_BW-1:0] lane_of(input logic [HPI_DW-1:0] w,
                                                  input int idx);
        return w[idx*HPI_BW +: HPI_BW];
    endfunction

    function automatic haddr_e lane_addr(input int idx);
        return haddr_e'(3'(int'(A_DLO) - idx));
    endfunction
endpackage

// File: rtl/hpi_h2c.sv
module hpi_h2c
    import hpi_pkg::*;
#(
    parameter int DW = HPI_DW,
    parameter int BW = HPI_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hwr,
    input  haddr_e        haddr,
    input  logic [BW-1:0] hwdata,
    input  logic          crd,
    output logic [DW-1:0] rx_word,
    output logic          rxf,
    output logic          txrdy
);
    localparam int NB = DW / BW;

    logic [DW-1:0] stage_w;
    logic          wr_lo;
    logic          move;

    assign wr_lo = hwr && txrdy && (haddr == A_DLO);
    assign move  = !txrdy && !rxf;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [BW-1:0] b_q;
        always_ff @(posedge clk) begin
            if (rst)
                b_q <= '0;
            else if (hwr && txrdy && (haddr == lane_addr(i)))
                b_q <= hwdata;
        end
        assign stage_w[i*BW +: BW] = b_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
            rxf     <= 1'b0;
            txrdy   <= 1'b1;
        end else if (move) begin
            rx_word <= stage_w;
            rxf     <= 1'b1;
            txrdy   <= 1'b1;
        end else begin
            if (crd)   rxf   <= 1'b0;
            if (wr_lo) txrdy <= 1'b0;
        end
    end

    // R3
    rxf_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rxf) |-> $past(!txrdy));
    // R3
    txrdy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txrdy) |-> $past(hwr && haddr == A_DLO));
    // R4
    rxf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rxf && !crd) |=> rxf);
endmodule

// File: rtl/hpi_c2h.sv
module hpi_c2h
    import hpi_pkg::*;
#(
    parameter int DW = HPI_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctx_wr,
    input  logic [DW-1:0] ctx_data,
    input  logic          hrd,
    input  haddr_e        haddr,
    output logic [DW-1:0] host_word,
    output logic          hrxrdy,
    output logic          txde
);
    logic [DW-1:0] tx_q;
    logic          accept;
    logic          move;
    logic          pop;

    assign accept = ctx_wr && txde;
    assign move   = !txde && !hrxrdy;
    assign pop    = hrd && (haddr == A_DLO);

    always_ff @(posedge clk) begin
        if (rst)
            tx_q <= '0;
        else if (accept)
            tx_q <= ctx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_word <= '0;
            hrxrdy    <= 1'b0;
            txde      <= 1'b1;
        end else if (move) begin
            host_word <= tx_q;
            hrxrdy    <= 1'b1;
            txde      <= 1'b1;
        end else begin
            if (accept) txde   <= 1'b0;
            if (pop)    hrxrdy <= 1'b0;
        end
    end

    // R6
    hrx_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hrxrdy) |-> $past(!txde));
    // R6
    txde_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txde) |-> $past(ctx_wr));
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
    import hpi_pkg::*;
#(
    parameter int BW = HPI_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hwr,
    input  haddr_e        haddr,
    input  logic [BW-1:0] hwdata,
    input  logic          cwr,
    input  logic [4:0]    cwdata,
    input  logic          cack,
    output hctl_t         hctl,
    output logic [BW-2:0] cvec,
    output logic [BW-1:0] ivec,
    output cctl_t         cctl,
    output logic          hcp
);
    logic cmd_set;

    assign cmd_set = hwr && (haddr == A_CVEC) && hwdata[BW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hctl <= '0;
            cvec <= '0;
            ivec <= '0;
        end else if (hwr) begin
            case (haddr)
                A_CTL:   hctl <= hctl_t'(hwdata[4:0] & HCTL_MASK);
                A_CVEC:  cvec <= hwdata[BW-2:0];
                A_IVEC:  ivec <= hwdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cctl <= '0;
        else if (cwr)
            cctl <= cctl_t'(cwdata);
    end

    always_ff @(posedge clk) begin
        if (rst)
            hcp <= 1'b0;
        else if (cmd_set)
            hcp <= 1'b1;
        else if (cack)
            hcp <= 1'b0;
    end

    // R8
    hcp_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cack && !(hwr && haddr == A_CVEC)) |=> !hcp);
    // R8
    hcp_raise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hcp) |-> $past(hwr && haddr == A_CVEC && hwdata[BW-1]));
endmodule

// File: rtl/hpi_bridge.sv
module hpi_bridge
    import hpi_pkg::*;
#(
    parameter int DW = HPI_DW,
    parameter int BW = HPI_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    h_addr,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [BW-1:0] h_wdata,
    output logic [BW-1:0] h_rdata,
    input  logic          h_ack,
    output logic          h_req,
    input  logic          c_tx_wr,
    input  logic [DW-1:0] c_tx_data,
    input  logic          c_rx_rd,
    output logic [DW-1:0] c_rx_data,
    input  logic          c_ctl_wr,
    input  logic [4:0]    c_ctl_wdata,
    output logic [4:0]    c_ctl,
    output logic [4:0]    c_stat,
    input  logic          c_cmd_ack,
    output logic          irq_rxf,
    output logic          irq_txe,
    output logic          irq_cmd
);
    haddr_e        ha;
    hctl_t         hctl;
    cctl_t         cctl;
    cstat_t        cst;
    logic [BW-2:0] cvec;
    logic [BW-1:0] ivec;
    logic          hcp;
    logic          rxf;
    logic          txrdy;
    logic          hrxrdy;
    logic          txde;
    logic [DW-1:0] host_word;

    assign ha = haddr_e'(h_addr);

    hpi_h2c #(.DW(DW), .BW(BW)) u_h2c (
        .clk(clk), .rst(rst), .hwr(h_wr), .haddr(ha), .hwdata(h_wdata),
        .crd(c_rx_rd), .rx_word(c_rx_data), .rxf(rxf), .txrdy(txrdy)
    );

    hpi_c2h #(.DW(DW)) u_c2h (
        .clk(clk), .rst(rst), .ctx_wr(c_tx_wr), .ctx_data(c_tx_data),
        .hrd(h_rd), .haddr(ha), .host_word(host_word),
        .hrxrdy(hrxrdy), .txde(txde)
    );

    hpi_regs #(.BW(BW)) u_regs (
        .clk(clk), .rst(rst), .hwr(h_wr), .haddr(ha), .hwdata(h_wdata),
        .cwr(c_ctl_wr), .cwdata(c_ctl_wdata), .cack(c_cmd_ack),
        .hctl(hctl), .cvec(cvec), .ivec(ivec), .cctl(cctl), .hcp(hcp)
    );

    always_comb begin
        cst.hfb  = hctl.hfb;
        cst.hfa  = hctl.hfa;
        cst.hcp  = hcp;
        cst.txde = txde;
        cst.rxf  = rxf;
    end

    assign c_stat = cst;
    assign c_ctl  = cctl;

    always_comb begin
        case (ha)
            A_CTL:   h_rdata = BW'(hctl);
            A_CVEC:  h_rdata = {hcp, cvec};
            A_STAT:  h_rdata = BW'({cctl.hfb, cctl.hfa, hcp, txrdy, hrxrdy});
            A_IVEC:  h_rdata = ivec;
            A_DHI, A_DMID, A_DLO:
                     h_rdata = lane_of(host_word, int'(A_DLO) - int'(ha));
            default: h_rdata = '0;
        endcase
    end

    assign h_req   = !h_ack && ((hctl.rreq && hrxrdy) || (hctl.treq && txrdy));
    assign irq_rxf = rxf  && cctl.rie;
    assign irq_txe = txde && cctl.tie;
    assign irq_cmd = hcp  && cctl.cie;

    // R3
    rxword_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(c_stat[0]) |-> $stable(c_rx_data));
endmodule

// File: tb/hpi_bridge_test.sv
module hpi_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  h_addr = '0;
    logic        h_wr = 1'b0, h_rd = 1'b0, h_ack = 1'b0;
    logic [7:0]  h_wdata = '0;
    logic [7:0]  h_rdata;
    logic        h_req;
    logic        c_tx_wr = 1'b0, c_rx_rd = 1'b0, c_ctl_wr = 1'b0, c_cmd_ack = 1'b0;
    logic [23:0] c_tx_data = '0;
    logic [23:0] c_rx_data;
    logic [4:0]  c_ctl_wdata = '0;
    logic [4:0]  c_ctl, c_stat;
    logic        irq_rxf, irq_txe, irq_cmd;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hpi_bridge uut (
        .clk(clk), .rst(rst), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack), .h_req(h_req),
        .c_tx_wr(c_tx_wr), .c_tx_data(c_tx_data), .c_rx_rd(c_rx_rd),
        .c_rx_data(c_rx_data), .c_ctl_wr(c_ctl_wr), .c_ctl_wdata(c_ctl_wdata),
        .c_ctl(c_ctl), .c_stat(c_stat), .c_cmd_ack(c_cmd_ack),
        .irq_rxf(irq_rxf), .irq_txe(irq_txe), .irq_cmd(irq_cmd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    logic [4:0]  m_hctl, m_cctl;
    logic [6:0]  m_cvec;
    logic [7:0]  m_ivec;
    logic        m_hcp;
    logic [7:0]  m_stage [3];
    logic [23:0] m_rx, m_ctx, m_hw;
    logic        m_txrdy, m_rxf, m_txde, m_hrx;

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {3'b000, m_hctl};
            3'd1: return {m_hcp, m_cvec};
            3'd2: return {3'b000, m_cctl[4:3], m_hcp, m_txrdy, m_hrx};
            3'd3: return m_ivec;
            3'd5: return m_hw[23:16];
            3'd6: return m_hw[15:8];
            3'd7: return m_hw[7:0];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hctl = 0; m_cctl = 0; m_cvec = 0; m_ivec = 0; m_hcp = 0;
            for (int i = 0; i < 3; i++) m_stage[i] = 0;
            m_rx = 0; m_ctx = 0; m_hw = 0;
            m_txrdy = 1; m_rxf = 0; m_txde = 1; m_hrx = 0;
        end else begin
            logic h2c_go, c2h_go;
            h2c_go = !m_txrdy && !m_rxf;
            c2h_go = !m_txde && !m_hrx;
            if (h2c_go) begin
                m_rx = {m_stage[0], m_stage[1], m_stage[2]};
                m_rxf = 1; m_txrdy = 1;
            end else begin
                if (c_rx_rd) m_rxf = 0;
                if (h_wr && m_txrdy && h_addr >= 3'd5) begin
                    m_stage[h_addr - 3'd5] = h_wdata;
                    if (h_addr == 3'd7) m_txrdy = 0;
                end
            end
            if (c2h_go) begin
                m_hw = m_ctx; m_hrx = 1; m_txde = 1;
            end else begin
                if (c_tx_wr && m_txde) begin m_ctx = c_tx_data; m_txde = 0; end
                if (h_rd && h_addr == 3'd7) m_hrx = 0;
            end
            if (h_wr && h_addr == 3'd0) m_hctl = h_wdata[4:0] & 5'b11011;
            if (h_wr && h_addr == 3'd1) m_cvec = h_wdata[6:0];
            if (h_wr && h_addr == 3'd3) m_ivec = h_wdata;
            if (h_wr && h_addr == 3'd1 && h_wdata[7]) m_hcp = 1;
            else if (c_cmd_ack) m_hcp = 0;
            if (c_ctl_wr) m_cctl = c_ctl_wdata;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk("R2 h_rdata", h_rdata, m_read(h_addr));
            chk("R11 h_req", h_req, !h_ack && ((m_hctl[0] && m_hrx) || (m_hctl[1] && m_txrdy)));
            chk("R3 c_rx_data", c_rx_data, m_rx);
            chk("R8 c_stat", c_stat, {m_hctl[4:3], m_hcp, m_txde, m_rxf});
            chk("R12 c_ctl", c_ctl, m_cctl);
            chk("R10 irqs", {irq_rxf, irq_txe, irq_cmd},
                {m_rxf && m_cctl[0], m_txde && m_cctl[1], m_hcp && m_cctl[2]});
        end
    end

    task automatic hwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk); h_wr = 1'b0;
    endtask

    task automatic hpeek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); h_addr = a; #1;
        chk(tag, h_rdata, exp);
    endtask

    task automatic hpop;
        @(negedge clk); h_addr = 3'd7; h_rd = 1'b1;
        @(negedge clk); h_rd = 1'b0;
    endtask

    task automatic ctx(input logic [23:0] d);
        @(negedge clk); c_tx_data = d; c_tx_wr = 1'b1;
        @(negedge clk); c_tx_wr = 1'b0;
    endtask

    task automatic crd;
        @(negedge clk); c_rx_rd = 1'b1;
        @(negedge clk); c_rx_rd = 1'b0;
    endtask

    task automatic cctlw(input logic [4:0] d);
        @(negedge clk); c_ctl_wdata = d; c_ctl_wr = 1'b1;
        @(negedge clk); c_ctl_wr = 1'b0;
    endtask

    task automatic cack;
        @(negedge clk); c_cmd_ack = 1'b1;
        @(negedge clk); c_cmd_ack = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 c_stat", c_stat, 5'b00010);
        chk("R1 h_req", h_req, 1'b0);
        chk("R1 irqs", {irq_rxf, irq_txe, irq_cmd}, 3'b000);
        chk("R1 c_rx_data", c_rx_data, 24'h0);
        hpeek(3'd2, 8'h02, "R1 host status");

        // R2 register map, R11 request
        hwr(3'd0, 8'hFF);
        hpeek(3'd0, 8'h1B, "R2 control readback");
        chk("R11 request on transmit-ready", h_req, 1'b1);
        hwr(3'd3, 8'hA5);
        hpeek(3'd3, 8'hA5, "R2 interrupt vector");
        hwr(3'd4, 8'hFF);
        hpeek(3'd4, 8'h00, "R2 gap reads zero");
        hwr(3'd1, 8'h12);
        hpeek(3'd1, 8'h12, "R2 command vector");
        chk("R8 no command without bit7", c_stat[2], 1'b0);
        hwr(3'd0, 8'h00);

        // R3 host to core word
        hwr(3'd5, 8'h12); hwr(3'd6, 8'h34); hwr(3'd7, 8'h56);
        @(negedge clk);
        chk("R3 word to core", c_rx_data, 24'h123456);
        chk("R3 receive-full", c_stat[0], 1'b1);
        hpeek(3'd2, 8'h02, "R7 status after move");

        // R4 waiting word, R5 ignored writes
        hwr(3'd5, 8'hAA); hwr(3'd6, 8'hBB); hwr(3'd7, 8'hCC);
        @(negedge clk);
        chk("R4 core word held", c_rx_data, 24'h123456);
        hpeek(3'd2, 8'h00, "R4 transmit-ready clear");
        hwr(3'd5, 8'hFF); hwr(3'd7, 8'hFF);
        crd;
        @(negedge clk);
        chk("R4 waiting word moved", c_rx_data, 24'hAABBCC);
        chk("R5 blocked writes ignored", c_rx_data, 24'hAABBCC);
        crd;

        // R6 core to host
        ctx(24'hABCDEF);
        @(negedge clk);
        hpeek(3'd5, 8'hAB, "R6 high byte");
        hpeek(3'd6, 8'hCD, "R6 middle byte");
        hpeek(3'd7, 8'hEF, "R6 low byte");
        hpeek(3'd2, 8'h03, "R7 receive-ready");
        ctx(24'h111111);
        ctx(24'h222222);
        chk("R6 transmit-empty clear", c_stat[1], 1'b0);
        hpop;
        @(negedge clk);
        hpeek(3'd5, 8'h11, "R6 second word kept");
        hpeek(3'd7, 8'h11, "R6 third strobe ignored");
        hpop;
        @(negedge clk);
        hpeek(3'd2, 8'h02, "R6 host receive empty");

        // R8 command
        hwr(3'd1, 8'h85);
        chk("R8 command pending", c_stat[2], 1'b1);
        hpeek(3'd1, 8'h85, "R8 vector shows pending");
        hpeek(3'd2, 8'h06, "R7 command in host status");
        cack;
        chk("R8 ack clears", c_stat[2], 1'b0);
        @(negedge clk); h_addr = 3'd1; h_wdata = 8'h80; h_wr = 1'b1; c_cmd_ack = 1'b1;
        @(negedge clk); h_wr = 1'b0; c_cmd_ack = 1'b0;
        chk("R8 set wins over ack", c_stat[2], 1'b1);
        cack;

        // R9 flags, R12 core control
        hwr(3'd0, 8'h18);
        chk("R9 host flags to core", c_stat[4:3], 2'b11);
        cctlw(5'b11000);
        chk("R12 core control", c_ctl, 5'b11000);
        hpeek(3'd2, 8'h1A, "R9 core flags to host");

        // R10 interrupts
        cctlw(5'b00111);
        chk("R10 txe irq", {irq_rxf, irq_txe, irq_cmd}, 3'b010);
        hwr(3'd1, 8'h80);
        chk("R10 cmd irq", irq_cmd, 1'b1);
        cctlw(5'b00000);
        chk("R10 masked", {irq_rxf, irq_txe, irq_cmd}, 3'b000);
        cack;

        // R11 request and acknowledge
        hwr(3'd0, 8'h01);
        chk("R11 no data no request", h_req, 1'b0);
        ctx(24'h0F0F0F);
        @(negedge clk);
        chk("R11 request on receive-ready", h_req, 1'b1);
        h_ack = 1'b1; #1;
        chk("R11 ack withdraws", h_req, 1'b0);
        @(negedge clk); h_ack = 1'b0; #1;
        chk("R11 ack released", h_req, 1'b1);
        hpop;
        chk("R11 pop drops request", h_req, 1'b0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule